// File: doc/BRIEF.md
# Narrow Instruction Expansion Unit

This unit sits between instruction fetch and decode in a 32-bit core that can run code in two widths. While the unit is in normal mode, each fetched word goes to the output as it is. A dedicated mode-switch instruction puts the unit into reduced mode. In reduced mode each fetched word carries two 16-bit narrow instructions. The unit rebuilds each of them, one per cycle, into the full 32-bit instruction that decode expects. The upper half is always issued first.

The full opcode of a narrow instruction comes from a lookup table, and the table is chosen at run time. The mode-switch instruction carries a configuration number in its immediate field, and the unit keeps that number to pick one of several 16-entry tables. Each routine can therefore use its own small opcode set. The tables are filled through a write port before the code that needs them runs.

The controller has three states:
- `S_NORM`: normal pass-through.
- `S_HI`: reduced mode, waiting for a word, issues its upper half.
- `S_LO`: issues the held lower half.

The transitions are:
- `S_NORM` to `S_HI`: on an accepted mode-switch word.
- `S_HI` to `S_LO`: on an accepted word whose upper half is not an exit.
- `S_HI` to `S_NORM`: when the upper half is an exit.
- `S_LO` to `S_HI`: when the lower half is not an exit.
- `S_LO` to `S_NORM`: when the lower half is an exit.

Top module: `nix_expander`

## Requirements
- R1: In normal mode an accepted fetch word appears on `out_word` with `out_valid` high one cycle after acceptance, bit for bit unchanged.
- R2: A normal-mode word with bits [31:26] equal to 6'b111101 is a mode switch. It is passed through like any other word, puts the unit into reduced mode, and latches bits [1:0] of the word as the configuration number.
- R3: In reduced mode, bits [31:16] of an accepted word are issued one cycle after acceptance. Bits [15:0] are issued in the following cycle. `in_ready` is low during the cycle in which the lower half is pending.
- R4: A narrow instruction holds the table index in [15:12], rs in [11:8], rt in [7:4] and the immediate in [3:0]. It expands to the table opcode in [31:26], rs zero-extended in [25:21], rt zero-extended in [20:16], and the immediate sign-extended in [15:0].
- R5: The opcode is read from the table picked by the latched configuration number, at the narrow index. A table write through the `cfg_*` port takes effect for every later translation.
- R6: The narrow halfword 16'h0000 is a no-op and expands to 32'h00000000.
- R7: A narrow instruction with index 4'hF is an exit. It issues 32'h00000000 and returns the unit to normal mode. If the exit is in the upper half, the lower half of that word is discarded.
- R8: A synchronous reset selects normal mode and configuration 0. It clears `out_valid` and raises `in_ready`, and it also abandons a pending lower half.
- R9: `out_valid` is high only for issued instructions: one per word accepted in normal mode, and one per narrow half issued in reduced mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetch word valid |
| in_ready | output | 1 | Unit can take a fetch word |
| in_word | input | 32 | Fetch word |
| cfg_we | input | 1 | Opcode table write enable |
| cfg_sel | input | 2 | Table (configuration) to write |
| cfg_idx | input | 4 | Narrow index to write |
| cfg_op | input | 6 | Full opcode stored at that index |
| out_valid | output | 1 | Expanded instruction valid |
| out_word | output | 32 | Expanded or passed-through instruction |

## Verification
The hardest situation to reach is a reset that lands while a lower half is still held. The stimulus gets there by accepting a reduced word and then raising reset in the very next cycle, before the held half can issue. It then checks that nothing is issued and that the next word passes through unchanged. A second hard case is an exit in the upper half, where the lower half must vanish. A dedicated vector places junk in that lower half and follows it with a normal word. The check then confirms that the junk never reaches the output stream.

// File: rtl/nix_pkg.sv
package nix_pkg;
    localparam int WORD_W = 32;
    localparam int HALF_W = 16;
    localparam int OPC_W  = 6;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 16;
    localparam int NF_W   = 4;   // width of each narrow field

    typedef enum logic [1:0] {
        S_NORM = 2'd0,
        S_HI   = 2'd1,
        S_LO   = 2'd2
    } nix_state_e;
endpackage

// File: rtl/nix_optable.sv
module nix_optable #(
    parameter int NUM_CFG = 4,
    parameter int DEPTH   = 16,
    parameter int OPC_W   = 6
) (
    input  logic                       clk,
    input  logic                       we,
    input  logic [$clog2(NUM_CFG)-1:0] wsel,
    input  logic [$clog2(DEPTH)-1:0]   widx,
    input  logic [OPC_W-1:0]           wop,
    input  logic [$clog2(NUM_CFG)-1:0] rsel,
    input  logic [$clog2(DEPTH)-1:0]   ridx,
    output logic [OPC_W-1:0]           rop
);
    localparam int SEL_W = $clog2(NUM_CFG);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int AW    = SEL_W + IDX_W;
    localparam int ENTRIES = NUM_CFG * DEPTH;

    logic [OPC_W-1:0] tbl_q [ENTRIES];
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;

    assign waddr = {wsel, widx};
    assign raddr = {rsel, ridx};

    always_ff @(posedge clk) begin
        if (we) begin
            tbl_q[waddr] <= wop;
        end
    end

    assign rop = tbl_q[raddr];
endmodule

// File: rtl/nix_widen.sv
module nix_widen
    import nix_pkg::*;
#(
    parameter logic [NF_W-1:0] EXIT_IDX = 4'hF
) (
    input  logic [HALF_W-1:0] half,
    input  logic [OPC_W-1:0]  opc,
    output logic              is_exit,
    output logic [WORD_W-1:0] wide
);
    logic [NF_W-1:0]  f_idx;
    logic [NF_W-1:0]  f_rs;
    logic [NF_W-1:0]  f_rt;
    logic [NF_W-1:0]  f_imm;
    logic [REG_W-1:0] w_rs;
    logic [REG_W-1:0] w_rt;
    logic [IMM_W-1:0] w_imm;

    assign {f_idx, f_rs, f_rt, f_imm} = half;
    assign is_exit = (f_idx == EXIT_IDX);

    assign w_rs  = {{(REG_W-NF_W){1'b0}}, f_rs};
    assign w_rt  = {{(REG_W-NF_W){1'b0}}, f_rt};
    assign w_imm = {{(IMM_W-NF_W){f_imm[NF_W-1]}}, f_imm};

    always_comb begin
        if (is_exit || half == '0) begin
            wide = '0;
        end else begin
            wide = {opc, w_rs, w_rt, w_imm};
        end
    end
endmodule

// File: rtl/nix_expander.sv
module nix_expander
    import nix_pkg::*;
#(
    parameter int              NUM_CFG  = 4,
    parameter int              DEPTH    = 16,
    parameter logic [OPC_W-1:0] ENTER_OP = 6'b111101,
    parameter logic [NF_W-1:0]  EXIT_IDX = 4'hF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    output logic                       in_ready,
    input  logic [WORD_W-1:0]          in_word,
    input  logic                       cfg_we,
    input  logic [$clog2(NUM_CFG)-1:0] cfg_sel,
    input  logic [$clog2(DEPTH)-1:0]   cfg_idx,
    input  logic [OPC_W-1:0]           cfg_op,
    output logic                       out_valid,
    output logic [WORD_W-1:0]          out_word
);
    localparam int SEL_W = $clog2(NUM_CFG);
    localparam int IDX_W = $clog2(DEPTH);

    nix_state_e        state_q, state_d;
    logic [HALF_W-1:0] hold_q;
    logic [SEL_W-1:0]  cfg_q;
    logic [HALF_W-1:0] cur_half;
    logic [OPC_W-1:0]  tbl_op;
    logic [WORD_W-1:0] wide;
    logic              is_exit;
    logic              accept;
    logic              is_enter;
    logic              ov_d;
    logic [WORD_W-1:0] ow_d;

    assign in_ready = (state_q != S_LO);
    assign accept   = in_valid && in_ready;
    assign is_enter = (in_word[WORD_W-1 -: OPC_W] == ENTER_OP);
    assign cur_half = (state_q == S_LO) ? hold_q : in_word[WORD_W-1 -: HALF_W];

    nix_optable #(
        .NUM_CFG (NUM_CFG),
        .DEPTH   (DEPTH),
        .OPC_W   (OPC_W)
    ) u_tbl (
        .clk  (clk),
        .we   (cfg_we),
        .wsel (cfg_sel),
        .widx (cfg_idx),
        .wop  (cfg_op),
        .rsel (cfg_q),
        .ridx (cur_half[HALF_W-1 -: IDX_W]),
        .rop  (tbl_op)
    );

    nix_widen #(
        .EXIT_IDX (EXIT_IDX)
    ) u_widen (
        .half    (cur_half),
        .opc     (tbl_op),
        .is_exit (is_exit),
        .wide    (wide)
    );

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_NORM: if (accept && is_enter) state_d = S_HI;
            S_HI:   if (accept) state_d = is_exit ? S_NORM : S_LO;
            S_LO:   state_d = is_exit ? S_NORM : S_HI;
            default: state_d = S_NORM;
        endcase
    end

    // state register with its companion holding registers
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_NORM;
            cfg_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_NORM && accept && is_enter) begin
                cfg_q <= in_word[SEL_W-1:0];
            end
            if (state_q == S_HI && accept) begin
                hold_q <= in_word[HALF_W-1:0];
            end
        end
    end

    // output decision
    always_comb begin
        ov_d = 1'b0;
        ow_d = '0;
        unique case (state_q)
            S_NORM: begin
                ov_d = accept;
                ow_d = in_word;
            end
            S_HI: begin
                ov_d = accept;
                ow_d = wide;
            end
            S_LO: begin
                ov_d = 1'b1;
                ow_d = wide;
            end
            default: begin
                ov_d = 1'b0;
                ow_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= ov_d;
            out_word  <= ow_d;
        end
    end
endmodule

// File: rtl/nix_expander_chk.sv
module nix_expander_chk
    import nix_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [WORD_W-1:0] in_word,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_word,
    input nix_state_e        state_q,
    input logic [HALF_W-1:0] hold_q
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_NORM && in_valid) |=> (out_valid && out_word == $past(in_word))); // R1

    AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |=> out_valid); // R3

    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (rst)
        (!in_ready) |=> in_ready); // R3

    AST_NOP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LO && hold_q == '0) |=> (out_valid && out_word == '0)); // R6

    AST_EXIT_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LO && hold_q[HALF_W-1 -: 4] == 4'hF) |=> (state_q == S_NORM && in_ready)); // R7

    AST_RESET_NORMAL: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_valid)); // R8

    AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past((in_valid && in_ready) || state_q == S_LO)); // R9
endmodule

bind nix_expander nix_expander_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_word   (in_word),
    .out_valid (out_valid),
    .out_word  (out_word),
    .state_q   (state_q),
    .hold_q    (hold_q)
);

// File: tb/nix_expander_tb.sv
module nix_expander_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_word = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_idx = '0;
    logic [5:0]  cfg_op = '0;
    logic        out_valid;
    logic [31:0] out_word;

    int n_run  = 0;
    int n_fail = 0;
    bit mon_en = 1'b0;
    int nobs   = 0;
    logic [31:0] obs [32];

    always #10 clk = ~clk;   // 50 MHz

    nix_expander u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_word   (in_word),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_idx   (cfg_idx),
        .cfg_op    (cfg_op),
        .out_valid (out_valid),
        .out_word  (out_word)
    );

    // fetch words fed in order
    localparam int NV = 10;
    localparam logic [31:0] VIN [NV] = '{
        32'h1234_5678,   // R1 plain word
        32'hF400_0000,   // R2 enter, config 0
        32'h824F_1237,   // R3 R4 two narrow ops
        32'h0000_F000,   // R6 nop, R7 exit in lower half
        32'hF400_0002,   // R2 enter, config 2
        32'h8F18_0000,   // R4 R5 table 2, negative imm
        32'hF000_5555,   // R7 exit in upper half, lower dropped
        32'h5555_AAAA,   // R1 back in normal mode
        32'hF400_0003,   // R2 enter, config 3
        32'h3A96_F000    // R5 table 3, then exit
    };
    // expected output stream, in issue order
    localparam int NE = 14;
    localparam logic [31:0] VEXP [NE] = '{
        32'h1234_5678, 32'hF400_0000,
        32'h2044_FFFF, 32'h0443_0007,
        32'h0000_0000, 32'h0000_0000,
        32'hF400_0002,
        32'hA1E1_FFF8, 32'h0000_0000,
        32'h0000_0000,
        32'h5555_AAAA, 32'hF400_0003,
        32'hCD49_0006, 32'h0000_0000
    };

    always @(negedge clk) begin
        if (mon_en && out_valid) begin
            if (nobs < 32) obs[nobs] = out_word;
            nobs = nobs + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run = n_run + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic tbl_write(input logic [1:0] s, input logic [3:0] i, input logic [5:0] op);
        @(negedge clk);
        cfg_we  = 1'b1;
        cfg_sel = s;
        cfg_idx = i;
        cfg_op  = op;
        @(negedge clk);
        cfg_we  = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail = n_fail + 1;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R8 reset state",
              {30'd0, in_ready, out_valid}, 32'h2);
        rst = 1'b0;

        // opcode table: config c, index i holds {c, i}
        for (int c = 0; c < 4; c++) begin
            for (int i = 0; i < 16; i++) begin
                tbl_write(2'(c), 4'(i), {2'(c), 4'(i)});
            end
        end

        mon_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            send(VIN[v]);
        end
        repeat (3) @(negedge clk);
        mon_en = 1'b0;

        check(nobs == NE, "R9 issued count", 32'(nobs), 32'(NE));
        for (int k = 0; k < NE; k++) begin
            check(k < nobs && obs[k] === VEXP[k], "R1-stream/R4 expansion", obs[k], VEXP[k]);
        end

        // R5: rewrite config 1 index 2 and use it
        tbl_write(2'd1, 4'd2, 6'h23);
        send(32'hF400_0001);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'h2125_0000;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_word === 32'h8C22_0005, "R5 rewritten entry", out_word, 32'h8C22_0005);
        check(in_ready === 1'b0, "R3 ready low for lower half", {31'd0, in_ready}, 32'd0);
        @(negedge clk);
        check(out_valid && out_word === 32'h0, "R6 nop lower half", out_word, 32'h0);
        check(in_ready === 1'b1, "R3 ready back", {31'd0, in_ready}, 32'd1);

        // R7: exit then a plain word must pass
        send(32'h0000_F000);
        send(32'hCAFE_BABE);
        check(out_valid && out_word === 32'hCAFE_BABE, "R7 normal after exit", out_word, 32'hCAFE_BABE);

        // R8: reset while the lower half is pending
        send(32'hF400_0002);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = 32'h1111_2222;
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R8 reset drops pending half",
              {30'd0, in_ready, out_valid}, 32'h2);
        rst = 1'b0;
        send(32'h0BAD_0BAD);
        check(out_valid && out_word === 32'h0BAD_0BAD, "R8 normal after reset", out_word, 32'h0BAD_0BAD);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule